// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the register file and single 16-bit transfer bus of a small accumulator machine. It holds six bus-connected registers: two 12-bit address-class registers (address pointer and program counter), three 16-bit registers (data, instruction, temporary) and an 8-bit output character register. It also holds an 8-bit input character register that is loaded from a device port. The accumulator lives outside the block, and its value arrives on a port so that it can be placed on the bus.

Every cycle, the control sequencer outside the block raises one or more of seven source requests. A priority encoder turns them into a 3-bit source code, and the bus carries the chosen source. Any register whose load strobe is high captures the bus at the next rising edge. The sequencer runs one transfer per cycle. The memory array is also outside the block: the address register always addresses it, the bus is always its write data, and its read data is one of the bus sources.

Top module: `bus_xfer_core`

## Requirements
- R1: Request k (bit k-1 of `src_req`, k = 1..7) produces `bus_sel_o` = k. When several requests are high, the highest k wins. With no request, `bus_sel_o` = 0 and the bus reads all zero.
- R2: Source codes map as follows: 1 address register, 2 program counter, 3 data register, 4 `acc_in`, 5 instruction register, 6 temporary register, 7 `mem_rdata`.
- R3: When a 12-bit register drives the bus (code 1 or 2), bus bits 15..12 are zero.
- R4: With `out_ld` high, the output register captures bus bits 7..0 at the rising edge. Otherwise it holds.
- R5: The four counting registers are indexed in `lic_*` as 0 address, 1 program counter, 2 data, 3 temporary. For each of them clear beats load, and load beats increment. Increment wraps to zero at the register width. With no control high, the register holds.
- R6: The address register and the program counter load bus bits 11..0.
- R7: The instruction register loads the full bus only when `ir_ld` is high, and holds otherwise.
- R8: `mem_addr` always equals the address register, and `mem_wdata` always equals the bus in the same cycle.
- R9: The input register captures `dev_char` when `in_ld` is high, and holds otherwise.
- R10: While `rst_n` is low, every register reads zero. After `rst_n` rises, the registers stay at zero through two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 7 | Bus source requests, bit k-1 = source code k |
| lic_ld | input | 4 | Load strobes of the counting registers |
| lic_inc | input | 4 | Increment strobes of the counting registers |
| lic_clr | input | 4 | Clear strobes of the counting registers |
| ir_ld | input | 1 | Instruction register load |
| out_ld | input | 1 | Output register load from bus low byte |
| in_ld | input | 1 | Input register load from device |
| dev_char | input | 8 | Character from the input device |
| acc_in | input | 16 | Accumulator value offered to the bus |
| mem_rdata | input | 16 | Memory read data offered to the bus |
| bus_o | output | 16 | Current bus value |
| bus_sel_o | output | 3 | Current source code |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| out_q | output | 8 | Output register |
| in_q | output | 8 | Input register |

## Verification
Request vectors are applied in three forms: empty, single-hot and multi-hot. The single-hot vectors separate each source code from its neighbours. The multi-hot vectors show whether the encoder obeys highest-wins or merely ORs the codes. The empty vector shows that the bus is zero rather than holding its last value. Control strobes are drawn so that clear, load and increment often coincide on one register, which exposes any swapped priority. Two directed cases are added: a 12-bit wrap from 0xFFF, and a 12-bit source on a bus whose upper nibble would otherwise be nonzero.

// File: rtl/busx_pkg.sv
package busx_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_ADDR = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DATA = 3'd3,
    SRC_ACC  = 3'd4,
    SRC_INST = 3'd5,
    SRC_TEMP = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  localparam int unsigned NUM_REQ  = 7;
  localparam int unsigned NUM_LIC  = 4;
  localparam int unsigned LIC_ADDR = 0;
  localparam int unsigned LIC_PC   = 1;
  localparam int unsigned LIC_DATA = 2;
  localparam int unsigned LIC_TEMP = 3;

endpackage

// File: rtl/busx_rst_sync.sv
module busx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/bus_src_enc.sv
module bus_src_enc #(
  parameter int unsigned N_REQ = 7,
  parameter int unsigned SEL_W = $clog2(N_REQ + 1)
) (
  input  logic [N_REQ-1:0] req,
  output logic [SEL_W-1:0] sel
);

  // Priority chain: each stage overrides the lower-numbered result.
  logic [SEL_W-1:0] chain [N_REQ+1];

  assign chain[0] = '0;

  for (genvar k = 0; k < N_REQ; k++) begin : g_stage
    assign chain[k+1] = req[k] ? SEL_W'(k + 1) : chain[k];
  end

  assign sel = chain[N_REQ];

endmodule

// File: rtl/bus_src_mux.sv
module bus_src_mux import busx_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  bus_src_e          sel,
  input  logic [ADDR_W-1:0] ar,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] dr,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] ir,
  input  logic [DATA_W-1:0] tr,
  input  logic [DATA_W-1:0] mrd,
  output logic [DATA_W-1:0] bus
);

  localparam int unsigned PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] ar_ext;
  logic [DATA_W-1:0] pc_ext;

  assign ar_ext = {{PAD_W{1'b0}}, ar};
  assign pc_ext = {{PAD_W{1'b0}}, pc};

  always_comb begin
    case (sel)
      SRC_ADDR: bus = ar_ext;
      SRC_PC:   bus = pc_ext;
      SRC_DATA: bus = dr;
      SRC_ACC:  bus = acc;
      SRC_INST: bus = ir;
      SRC_TEMP: bus = tr;
      SRC_MEM:  bus = mrd;
      default:  bus = '0;
    endcase
  end

endmodule

// File: rtl/busx_reg.sv
module busx_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic         en;
  logic [W-1:0] q_nxt;

  always_comb begin
    en = clr | ld | inc;
    if (clr) begin
      q_nxt = '0;
    end else if (ld) begin
      q_nxt = d;
    end else begin
      q_nxt = q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/bus_xfer_core.sv
module bus_xfer_core import busx_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CHAR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] src_req,
  input  logic [NUM_LIC-1:0] lic_ld,
  input  logic [NUM_LIC-1:0] lic_inc,
  input  logic [NUM_LIC-1:0] lic_clr,
  input  logic               ir_ld,
  input  logic               out_ld,
  input  logic               in_ld,
  input  logic [CHAR_W-1:0]  dev_char,
  input  logic [DATA_W-1:0]  acc_in,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  bus_o,
  output logic [2:0]         bus_sel_o,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [ADDR_W-1:0]  ar_q,
  output logic [ADDR_W-1:0]  pc_q,
  output logic [DATA_W-1:0]  dr_q,
  output logic [DATA_W-1:0]  ir_q,
  output logic [DATA_W-1:0]  tr_q,
  output logic [CHAR_W-1:0]  out_q,
  output logic [CHAR_W-1:0]  in_q
);

  logic              rst_core_n;
  logic [2:0]        sel_raw;
  bus_src_e          sel;
  logic [DATA_W-1:0] bus_w;

  busx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bus_src_enc #(.N_REQ(NUM_REQ), .SEL_W(3)) u_enc (
    .req (src_req),
    .sel (sel_raw)
  );

  assign sel = bus_src_e'(sel_raw);

  bus_src_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .sel (sel),
    .ar  (ar_q),
    .pc  (pc_q),
    .dr  (dr_q),
    .acc (acc_in),
    .ir  (ir_q),
    .tr  (tr_q),
    .mrd (mem_rdata),
    .bus (bus_w)
  );

  busx_reg #(.W(ADDR_W)) u_ar (
    .clk (clk), .rst_n (rst_core_n),
    .clr (lic_clr[LIC_ADDR]), .ld (lic_ld[LIC_ADDR]), .inc (lic_inc[LIC_ADDR]),
    .d   (bus_w[ADDR_W-1:0]), .q (ar_q)
  );

  busx_reg #(.W(ADDR_W)) u_pc (
    .clk (clk), .rst_n (rst_core_n),
    .clr (lic_clr[LIC_PC]), .ld (lic_ld[LIC_PC]), .inc (lic_inc[LIC_PC]),
    .d   (bus_w[ADDR_W-1:0]), .q (pc_q)
  );

  busx_reg #(.W(DATA_W)) u_dr (
    .clk (clk), .rst_n (rst_core_n),
    .clr (lic_clr[LIC_DATA]), .ld (lic_ld[LIC_DATA]), .inc (lic_inc[LIC_DATA]),
    .d   (bus_w), .q (dr_q)
  );

  busx_reg #(.W(DATA_W)) u_tr (
    .clk (clk), .rst_n (rst_core_n),
    .clr (lic_clr[LIC_TEMP]), .ld (lic_ld[LIC_TEMP]), .inc (lic_inc[LIC_TEMP]),
    .d   (bus_w), .q (tr_q)
  );

  busx_reg #(.W(DATA_W)) u_ir (
    .clk (clk), .rst_n (rst_core_n),
    .clr (1'b0), .ld (ir_ld), .inc (1'b0),
    .d   (bus_w), .q (ir_q)
  );

  busx_reg #(.W(CHAR_W)) u_out (
    .clk (clk), .rst_n (rst_core_n),
    .clr (1'b0), .ld (out_ld), .inc (1'b0),
    .d   (bus_w[CHAR_W-1:0]), .q (out_q)
  );

  busx_reg #(.W(CHAR_W)) u_in (
    .clk (clk), .rst_n (rst_core_n),
    .clr (1'b0), .ld (in_ld), .inc (1'b0),
    .d   (dev_char), .q (in_q)
  );

  assign bus_o     = bus_w;
  assign bus_sel_o = sel_raw;
  assign mem_addr  = ar_q;
  assign mem_wdata = bus_w;

endmodule

// File: rtl/bus_xfer_chk.sv
module bus_xfer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [6:0]        src_req,
  input logic              ar_clr,
  input logic              ar_ld,
  input logic              pc_clr,
  input logic              pc_ld,
  input logic              pc_inc,
  input logic              ir_ld,
  input logic              out_ld,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] bus_o,
  input logic [2:0]        bus_sel_o,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [CHAR_W-1:0] out_q
);

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (src_req == 7'd0) |-> (bus_sel_o == 3'd0 && bus_o == '0));

  assert_mem_wins_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    src_req[6] |-> (bus_sel_o == 3'd7 && bus_o == mem_rdata));

  assert_acc_src_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (src_req[6:3] == 4'b0001) |-> (bus_o == acc_in));

  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel_o == 3'd1 || bus_sel_o == 3'd2) |-> (bus_o[DATA_W-1:ADDR_W] == '0));

  assert_out_low_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_ld |=> (out_q == $past(bus_o[CHAR_W-1:0])));

  assert_clr_first_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    ar_clr |=> (ar_q == '0));

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pc_inc && !pc_ld && !pc_clr) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_ar_load_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ar_ld && !ar_clr) |=> (ar_q == $past(bus_o[ADDR_W-1:0])));

  assert_ir_hold_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ir_ld |=> $stable(ir_q));

  assert_mem_ports_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_addr == ar_q && mem_wdata == bus_o));

endmodule

bind bus_xfer_core bus_xfer_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CHAR_W (CHAR_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .src_req    (src_req),
  .ar_clr     (lic_clr[0]),
  .ar_ld      (lic_ld[0]),
  .pc_clr     (lic_clr[1]),
  .pc_ld      (lic_ld[1]),
  .pc_inc     (lic_inc[1]),
  .ir_ld      (ir_ld),
  .out_ld     (out_ld),
  .acc_in     (acc_in),
  .mem_rdata  (mem_rdata),
  .bus_o      (bus_o),
  .bus_sel_o  (bus_sel_o),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .ar_q       (ar_q),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .out_q      (out_q)
);

// File: tb/sim_bus_xfer_core.sv
`timescale 1ns/1ps
module sim_bus_xfer_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  src_req;
  logic [3:0]  lic_ld, lic_inc, lic_clr;
  logic        ir_ld, out_ld, in_ld;
  logic [7:0]  dev_char;
  logic [15:0] acc_in, mem_rdata;
  logic [15:0] bus_o, mem_wdata, dr_q, ir_q, tr_q;
  logic [2:0]  bus_sel_o;
  logic [11:0] mem_addr, ar_q, pc_q;
  logic [7:0]  out_q, in_q;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Bench model of register contents
  logic [15:0] ar_m, pc_m, dr_m, ir_m, tr_m, out_m, in_m;

  always #5 clk = ~clk;

  bus_xfer_core u0 (
    .clk (clk), .rst_n (rst_n), .src_req (src_req),
    .lic_ld (lic_ld), .lic_inc (lic_inc), .lic_clr (lic_clr),
    .ir_ld (ir_ld), .out_ld (out_ld), .in_ld (in_ld),
    .dev_char (dev_char), .acc_in (acc_in), .mem_rdata (mem_rdata),
    .bus_o (bus_o), .bus_sel_o (bus_sel_o),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .ar_q (ar_q), .pc_q (pc_q), .dr_q (dr_q), .ir_q (ir_q), .tr_q (tr_q),
    .out_q (out_q), .in_q (in_q)
  );

  function automatic logic [2:0] f_sel(input logic [6:0] r);
    logic [2:0] s = 3'd0;
    for (int k = 0; k < 7; k++) if (r[k]) s = 3'(k + 1);
    return s;
  endfunction

  function automatic logic [15:0] f_bus(input logic [2:0] s);
    case (s)
      3'd1: return {4'h0, ar_m[11:0]};
      3'd2: return {4'h0, pc_m[11:0]};
      3'd3: return dr_m;
      3'd4: return acc_in;
      3'd5: return ir_m;
      3'd6: return tr_m;
      3'd7: return mem_rdata;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] f_reg(input logic [15:0] q, input logic clr,
                                        input logic ld, input logic inc,
                                        input logic [15:0] d, input logic [15:0] mask);
    logic [15:0] n;
    if (clr)      n = 16'h0;
    else if (ld)  n = d;
    else if (inc) n = q + 16'h1;
    else          n = q;
    return n & mask;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    src_req = '0; lic_ld = '0; lic_inc = '0; lic_clr = '0;
    ir_ld = 0; out_ld = 0; in_ld = 0; dev_char = '0; acc_in = '0; mem_rdata = '0;
  endtask

  task automatic check_regs(input string tag);
    check({tag, " R6 ar"},  {4'h0, ar_q},  ar_m);
    check({tag, " R5 pc"},  {4'h0, pc_q},  pc_m);
    check({tag, " R5 dr"},  dr_q,          dr_m);
    check({tag, " R7 ir"},  ir_q,          ir_m);
    check({tag, " R5 tr"},  tr_q,          tr_m);
    check({tag, " R4 out"}, {8'h0, out_q}, out_m);
    check({tag, " R9 in"},  {8'h0, in_q},  in_m);
  endtask

  // One transfer: drive at the falling edge, check the bus mid-cycle,
  // advance the model at the rising edge, check registers after it.
  task automatic step(input logic [6:0] rq, input logic [3:0] ld, input logic [3:0] inc,
                      input logic [3:0] clr, input logic irl, input logic outl,
                      input logic inl, input logic [7:0] ch,
                      input logic [15:0] acc, input logic [15:0] mrd);
    logic [2:0]  es;
    logic [15:0] eb;
    @(negedge clk);
    src_req = rq; lic_ld = ld; lic_inc = inc; lic_clr = clr;
    ir_ld = irl; out_ld = outl; in_ld = inl; dev_char = ch;
    acc_in = acc; mem_rdata = mrd;
    #1;
    es = f_sel(rq);
    eb = f_bus(es);
    check("R1 select", {13'h0, bus_sel_o}, {13'h0, es});
    if (es == 3'd1 || es == 3'd2) check("R3 zero-fill bus", bus_o, eb);
    else                          check("R2 bus source", bus_o, eb);
    check("R8 mem_addr", {4'h0, mem_addr}, ar_m);
    check("R8 mem_wdata", mem_wdata, eb);
    ar_m  = f_reg(ar_m, clr[0], ld[0], inc[0], eb, 16'h0FFF);
    pc_m  = f_reg(pc_m, clr[1], ld[1], inc[1], eb, 16'h0FFF);
    dr_m  = f_reg(dr_m, clr[2], ld[2], inc[2], eb, 16'hFFFF);
    tr_m  = f_reg(tr_m, clr[3], ld[3], inc[3], eb, 16'hFFFF);
    ir_m  = f_reg(ir_m, 1'b0, irl, 1'b0, eb, 16'hFFFF);
    out_m = f_reg(out_m, 1'b0, outl, 1'b0, eb, 16'h00FF);
    in_m  = f_reg(in_m, 1'b0, inl, 1'b0, {8'h0, ch}, 16'h00FF);
    @(posedge clk);
    #2;
    check_regs("post-edge");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle_inputs();
    rst_n = 1'b0;
    ar_m = 0; pc_m = 0; dr_m = 0; ir_m = 0; tr_m = 0; out_m = 0; in_m = 0;
    repeat (3) @(posedge clk);
    #2;
    check_regs("R10 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // Loads requested during the synchronizer window must not land (R10)
    lic_ld = 4'hF; ir_ld = 1; src_req = 7'h40; mem_rdata = 16'hBEEF;
    @(posedge clk); #2;
    check("R10 held after release", {4'h0, ar_q}, 16'h0);
    @(negedge clk);
    idle_inputs();
    repeat (2) @(posedge clk);
    #2;
    check_regs("R10 after release");

    // Directed: load AR from memory (upper nibble dropped, R6)
    step(7'h40, 4'b0001, 4'h0, 4'h0, 0, 0, 0, 8'h00, 16'h0, 16'hA123);
    // AR onto bus: upper nibble zero (R3), into DR and TR
    step(7'h01, 4'b1100, 4'h0, 4'h0, 0, 0, 0, 8'h00, 16'h0, 16'h0);
    // Clear, load, increment together on AR: clear wins (R5)
    step(7'h40, 4'b0001, 4'b0001, 4'b0001, 0, 0, 0, 8'h00, 16'h0, 16'h5555);
    // Load and increment on PC: load wins (R5)
    step(7'h40, 4'b0010, 4'b0010, 4'h0, 0, 0, 0, 8'h00, 16'h0, 16'hFFFF);
    // PC increment wraps 0xFFF -> 0 (R5)
    step(7'h00, 4'h0, 4'b0010, 4'h0, 0, 0, 0, 8'h00, 16'h0, 16'h0);
    // Multi-hot: acc (4) and DR (3) and AR (1): acc wins (R1), into IR and OUT (R4, R7)
    step(7'h0D, 4'h0, 4'h0, 4'h0, 1, 1, 1, 8'h9C, 16'hC3A5, 16'h0);
    // All requests: memory wins (R1)
    step(7'h7F, 4'h0, 4'h0, 4'h0, 1, 0, 0, 8'h00, 16'h1111, 16'h7E81);
    // No request: bus zero (R1), loads capture zero
    step(7'h00, 4'b1100, 4'h0, 4'h0, 0, 1, 0, 8'h00, 16'hFFFF, 16'hFFFF);

    for (int n = 0; n < 1500; n++) begin
      logic [6:0] rq;
      rq = ($urandom_range(0, 7) == 0) ? 7'h00 : 7'($urandom);
      step(rq, 4'($urandom & $urandom), 4'($urandom & $urandom),
           4'($urandom & $urandom & $urandom),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), 8'($urandom),
           16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule